// File: doc/BRIEF.md
# Block-Transfer Channel Slot Sequencer

This block decides, slot by slot, which channel of a four-channel block-transfer engine uses the memory bus. Three channels (A, B, C) read source words. The fourth (D) writes result words. A job is launched with a one-cycle start pulse, a 4-bit channel-use mask and a word count. The sequencer then offers one slot at a time: fetch A, fetch B, fetch C, write D, or an idle slot. Each slot carries the index of the word it serves. An offered slot is only consumed when the bus grants it.

Result writes trail the source fetches by one word. The engine's internal pipeline needs two sets of source words before the first result is ready. It then needs a final write after the last fetch to empty the pipeline. Idle slots in the slot order are fixed per channel mix and are never removed, so the bus timing of a job is fully repeatable. A one-cycle done pulse closes each job.

Top module: `blitSeq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, slotValid, busy and done are all low.
- R2: Mask bit 3 enables A, bit 2 enables B, bit 1 enables C and bit 0 enables D. Slot codes are 0 for idle, 1 for A, 2 for B, 3 for C and 4 for D. Within a word, enabled sources come in the order A, B, C.
- R3: With D off, each word has one group of slots, per mask: E=A B C; C=A B idle; A=A C; 8=A idle; 6=B C idle; 4=B idle idle; 2=C idle. Trailing idle slots of the last word's group are dropped, and no other slots follow.
- R4: With D on and at least one source on, each word's group, per mask, is: F=A B C D; D=A B D; B=A C D; 9=A D; 7=B C D idle; 5=B D idle; 3=C D idle. The D slot of word n's group writes word n-1. In word 0 that slot is idle. After the last group comes a flush: D(last) for masks F, 7, 5, 3, and idle then D(last) for masks D, B, 9.
- R5: Mask 1 (D only) has no lag. Each word emits D(n) then idle, and the idle after the last word's D is dropped.
- R6: Any word count from 1 upward repeats the per-word group once per word. A 1-word job is the first group followed directly by the flush.
- R7: slotWord gives the word index of the offered slot. Source slots and in-group idle slots give the current word. A lagged D gives the previous word. Flush slots give the last word.
- R8: While slotValid is high and slotGrant is low, the sequence does not advance, and slotCode and slotWord hold their values.
- R9: done is high for exactly one cycle, starting in the cycle after the last slot is consumed. In the following cycle busy is low.
- R10: A start pulse while busy is ignored. The running job's slot order, word indices and length are unchanged.
- R11: A start with mask 0 or word count 0 produces no slot and raises done in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| useMask | input | 4 | Channel-use mask (A,B,C,D from MSB), sampled at start |
| wordCount | input | WORD_W | Words in the job, sampled at start |
| slotGrant | input | 1 | Bus grant for the offered slot |
| slotValid | output | 1 | A slot is being offered |
| slotCode | output | 3 | Kind of the offered slot |
| slotWord | output | WORD_W | Word index of the offered slot |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench runs every one of the sixteen masks with word counts 1 to 4, and some masks with a longer count. This separates the source-only, lagged-D and D-only slot orders, and separates the first group, the repeated middle groups, the last-group trimming and the flush. The sixteen masks are run again at a count of 3 under a pseudo-random grant pattern, which shows whether a stalled slot holds steady. A few runs pulse start with a different mask in the middle of a job, and a zero mask and zero count show the empty-job path.

// File: rtl/blitSeqPkg.sv
package blitSeqPkg;

  typedef enum logic [2:0] {
    SLOT_IDLE = 3'd0,
    SLOT_A    = 3'd1,
    SLOT_B    = 3'd2,
    SLOT_C    = 3'd3,
    SLOT_D    = 3'd4
  } slotCode_e;

  // per-mix slot layout
  typedef struct packed {
    logic [2:0] groupLen;
    logic [1:0] numSrc;
    logic       hasD;
    logic       lag;
    logic [1:0] flushLen;
  } mixCfg_t;

  // control -> datapath
  typedef struct packed {
    logic       load;
    logic       inFlush;
    logic [1:0] flushPos;
    logic [2:0] pos;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       emptyJob;
    logic       lastWord;
    logic [2:0] endPos;
    logic [1:0] flushLen;
  } pathStatus_t;

  function automatic mixCfg_t mixCfgOf(input logic [3:0] m);
    mixCfg_t c;
    c.numSrc = {1'b0, m[3]} + {1'b0, m[2]} + {1'b0, m[1]};
    c.hasD   = m[0];
    c.lag    = m[0] && (m[3:1] != 3'b000);
    case (m)
      4'hF, 4'h7:                      c.groupLen = 3'd4;
      4'hE, 4'hD, 4'hC, 4'hB, 4'h6,
      4'h5, 4'h4, 4'h3:                c.groupLen = 3'd3;
      4'hA, 4'h9, 4'h8, 4'h2, 4'h1:    c.groupLen = 3'd2;
      default:                         c.groupLen = 3'd0;
    endcase
    case (m)
      4'hF, 4'h7, 4'h5, 4'h3: c.flushLen = 2'd1;
      4'hD, 4'hB, 4'h9:       c.flushLen = 2'd2;
      default:                c.flushLen = 2'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/blitSeqPath.sv
module blitSeqPath
  import blitSeqPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] wordIdx,
  input  logic              slotValid,
  input  logic [3:0]        maskIn,
  input  logic [WORD_W-1:0] countIn,
  output pathStatus_t       status,
  output logic [2:0]        slotCode,
  output logic [WORD_W-1:0] slotWord
);

  localparam logic [WORD_W-1:0] WORD_ONE = WORD_W'(1);

  logic [3:0]        maskQ;
  logic [WORD_W-1:0] countQ;
  mixCfg_t           cfg;
  slotCode_e         srcCode;
  slotCode_e         codeNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= 4'h0;
      countQ <= '0;
    end else if (strobe.load) begin
      maskQ  <= maskIn;
      countQ <= countIn;
    end
  end

  assign cfg = mixCfgOf(maskQ);

  // pick the pos-th enabled source in A,B,C order
  always_comb begin
    int k;
    k = 0;
    srcCode = SLOT_IDLE;
    for (int i = 0; i < 3; i++) begin
      if (maskQ[3-i]) begin
        if (k == int'(strobe.pos)) srcCode = slotCode_e'(3'(i + 1));
        k = k + 1;
      end
    end
  end

  always_comb begin
    codeNext = SLOT_IDLE;
    slotWord = wordIdx;
    if (strobe.inFlush) begin
      codeNext = (strobe.flushPos == cfg.flushLen - 2'd1) ? SLOT_D : SLOT_IDLE;
      slotWord = countQ - WORD_ONE;
    end else if (strobe.pos < {1'b0, cfg.numSrc}) begin
      codeNext = srcCode;
    end else if (strobe.pos == {1'b0, cfg.numSrc} && cfg.hasD) begin
      if (!cfg.lag) begin
        codeNext = SLOT_D;
      end else if (wordIdx != '0) begin
        codeNext = SLOT_D;
        slotWord = wordIdx - WORD_ONE;
      end
    end
  end

  assign slotCode = codeNext;

  assign status.emptyJob = (maskIn == 4'h0) || (countIn == '0);
  assign status.lastWord = (wordIdx == countQ - WORD_ONE);
  assign status.flushLen = cfg.flushLen;
  assign status.endPos   = (status.lastWord && cfg.flushLen == 2'd0)
                         ? ({1'b0, cfg.numSrc} + {2'b00, cfg.hasD} - 3'd1)
                         : (cfg.groupLen - 3'd1);

  // R7: a D write never names a word past the job
  a_r7_dword_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && slotCode == SLOT_D) |-> (slotWord < countQ));

  // R4: no write in the first group of a lagged mix
  a_r4_first_group_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && !strobe.inFlush && wordIdx == '0 && cfg.lag) |-> (slotCode != SLOT_D));

endmodule

// File: rtl/blitSeqCtrl.sv
module blitSeqCtrl
  import blitSeqPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              slotGrant,
  input  pathStatus_t       status,
  output ctrlStrobe_t       strobe,
  output logic [WORD_W-1:0] wordIdx,
  output logic              slotValid,
  output logic              busy,
  output logic              done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

  state_e     stateQ;
  logic [2:0] posQ;
  logic [1:0] flushPosQ;
  logic       inFlushQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      posQ      <= 3'd0;
      flushPosQ <= 2'd0;
      inFlushQ  <= 1'b0;
      wordIdx   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (start) begin
          posQ      <= 3'd0;
          flushPosQ <= 2'd0;
          inFlushQ  <= 1'b0;
          wordIdx   <= '0;
          stateQ    <= status.emptyJob ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (slotGrant) begin
          if (inFlushQ) begin
            if (flushPosQ == status.flushLen - 2'd1) stateQ <= ST_FIN;
            else flushPosQ <= flushPosQ + 2'd1;
          end else if (posQ == status.endPos) begin
            if (!status.lastWord) begin
              wordIdx <= wordIdx + WORD_W'(1);
              posQ    <= 3'd0;
            end else if (status.flushLen != 2'd0) begin
              inFlushQ  <= 1'b1;
              flushPosQ <= 2'd0;
            end else begin
              stateQ <= ST_FIN;
            end
          end else begin
            posQ <= posQ + 3'd1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign strobe.load     = (stateQ == ST_IDLE) && start;
  assign strobe.inFlush  = inFlushQ;
  assign strobe.flushPos = flushPosQ;
  assign strobe.pos      = posQ;

  assign slotValid = (stateQ == ST_RUN);
  assign busy      = (stateQ != ST_IDLE);
  assign done      = (stateQ == ST_FIN);

  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a running job always ends through done
  a_r9_run_ends_via_done: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN) |=> (stateQ != ST_IDLE));

  // R10: start while running never rewinds the word index
  a_r10_start_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && start) |=> (wordIdx >= $past(wordIdx)));

  // R11: an empty job offers no slot
  a_r11_empty_no_slot: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && start && status.emptyJob) |=> (done && !slotValid));

endmodule

// File: rtl/blitSeq.sv
module blitSeq
  import blitSeqPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        useMask,
  input  logic [WORD_W-1:0] wordCount,
  input  logic              slotGrant,
  output logic              slotValid,
  output logic [2:0]        slotCode,
  output logic [WORD_W-1:0] slotWord,
  output logic              busy,
  output logic              done
);

  ctrlStrobe_t       strobe;
  pathStatus_t       status;
  logic [WORD_W-1:0] wordIdx;

  blitSeqCtrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .slotGrant (slotGrant),
    .status    (status),
    .strobe    (strobe),
    .wordIdx   (wordIdx),
    .slotValid (slotValid),
    .busy      (busy),
    .done      (done)
  );

  blitSeqPath #(.WORD_W(WORD_W)) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wordIdx   (wordIdx),
    .slotValid (slotValid),
    .maskIn    (useMask),
    .countIn   (wordCount),
    .status    (status),
    .slotCode  (slotCode),
    .slotWord  (slotWord)
  );

  // R8: a refused slot stays on the outputs
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && !slotGrant) |=> ($stable(slotCode) && $stable(slotWord) && slotValid));

  // R9: never offer a slot and finish at once
  a_r9_valid_excl_done: assert property (@(posedge clk) disable iff (!rstN)
    !(slotValid && done));

endmodule

// File: tb/blitSeq_tb.sv
module blitSeq_tb_top;

  localparam int WORD_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [3:0]        useMask = 4'h0;
  logic [WORD_W-1:0] wordCount = '0;
  logic              slotGrant = 1'b1;
  logic              slotValid;
  logic [2:0]        slotCode;
  logic [WORD_W-1:0] slotWord;
  logic              busy;
  logic              done;

  int applied = 0;
  int fails = 0;
  bit summaryDone = 0;
  int expCode [64];
  int expWord [64];
  int expLen;
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk;

  blitSeq #(.WORD_W(WORD_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .useMask(useMask),
    .wordCount(wordCount), .slotGrant(slotGrant), .slotValid(slotValid),
    .slotCode(slotCode), .slotWord(slotWord), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    applied++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // slot templates per mask, written from the requirements
  function automatic void tmpl(input logic [3:0] m, output string g, output string f);
    case (m)
      4'hF: begin g = "ABCD"; f = "D";  end
      4'hE: begin g = "ABC";  f = "";   end
      4'hD: begin g = "ABD";  f = "-D"; end
      4'hC: begin g = "AB-";  f = "";   end
      4'hB: begin g = "ACD";  f = "-D"; end
      4'hA: begin g = "AC";   f = "";   end
      4'h9: begin g = "AD";   f = "-D"; end
      4'h8: begin g = "A-";   f = "";   end
      4'h7: begin g = "BCD-"; f = "D";  end
      4'h6: begin g = "BC-";  f = "";   end
      4'h5: begin g = "BD-";  f = "D";  end
      4'h4: begin g = "B--";  f = "";   end
      4'h3: begin g = "CD-";  f = "D";  end
      4'h2: begin g = "C-";   f = "";   end
      4'h1: begin g = "D-";   f = "";   end
      default: begin g = ""; f = ""; end
    endcase
  endfunction

  function automatic void buildExp(input logic [3:0] m, input int cnt);
    string g, f;
    bit lagged;
    tmpl(m, g, f);
    lagged = (m[0] == 1'b1) && (m[3:1] != 3'b000);
    expLen = 0;
    if (m == 4'h0 || cnt == 0) return;
    for (int n = 0; n < cnt; n++) begin
      int len;
      len = g.len();
      if (n == cnt - 1 && f.len() == 0)
        while (len > 0 && g[len-1] == 8'h2D) len--;
      for (int i = 0; i < len; i++) begin
        case (g[i])
          8'h41: begin expCode[expLen] = 1; expWord[expLen] = n; end
          8'h42: begin expCode[expLen] = 2; expWord[expLen] = n; end
          8'h43: begin expCode[expLen] = 3; expWord[expLen] = n; end
          8'h44: begin
            if (!lagged) begin expCode[expLen] = 4; expWord[expLen] = n; end
            else if (n == 0) begin expCode[expLen] = 0; expWord[expLen] = 0; end
            else begin expCode[expLen] = 4; expWord[expLen] = n - 1; end
          end
          default: begin expCode[expLen] = 0; expWord[expLen] = n; end
        endcase
        expLen++;
      end
    end
    for (int i = 0; i < f.len(); i++) begin
      expCode[expLen] = (f[i] == 8'h44) ? 4 : 0;
      expWord[expLen] = cnt - 1;
      expLen++;
    end
  endfunction

  // mode 0: grant always; 1: pseudo-random stalls; 2: start poke mid-job
  task automatic runBlit(input logic [3:0] m, input int cnt, input int mode);
    int idx;
    int guard;
    bit finished;
    bit stalledBefore;
    string codeTag;
    buildExp(m, cnt);
    if (m == 4'h1) codeTag = "R5";
    else if (m[0]) codeTag = "R4";
    else codeTag = "R3";
    if (expLen == 0) codeTag = "R11";
    @(negedge clk);
    useMask = m; wordCount = WORD_W'(cnt); start = 1'b1; slotGrant = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; guard = 0; finished = 0; stalledBefore = 0;
    while (!finished && guard < 400) begin
      if (done) begin
        chk(idx == expLen, (mode == 2) ? "R10 length" : "R9 done timing", idx, expLen);
        finished = 1;
      end else if (slotValid) begin
        bit g;
        string tag;
        if (idx == 0) tag = "R2";
        else if (stalledBefore) tag = "R8";
        else if (mode == 2) tag = "R10";
        else if (cnt != 3) tag = "R6";
        else tag = codeTag;
        if (idx < expLen) begin
          chk(int'(slotCode) == expCode[idx], {tag, " code"}, int'(slotCode), expCode[idx]);
          chk(int'(slotWord) == expWord[idx], "R7 word", int'(slotWord), expWord[idx]);
        end else begin
          chk(1'b0, {codeTag, " extra slot"}, idx, expLen);
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        g = (mode == 1) ? lfsr[0] : 1'b1;
        slotGrant = g;
        stalledBefore = !g;
        if (mode == 2 && idx == 1) begin
          start = 1'b1; useMask = 4'hE; wordCount = WORD_W'(2);
        end
        if (g) idx++;
      end else begin
        chk(1'b0, {codeTag, " no slot and no done"}, idx, expLen);
        finished = 1;
      end
      @(negedge clk);
      start = 1'b0; useMask = m; wordCount = WORD_W'(cnt); slotGrant = 1'b1;
      guard++;
    end
    if (!finished) chk(1'b0, "R9 job never ended", idx, expLen);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    chk(busy == 1'b0, "R9 back to idle", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(slotValid == 1'b0, "R1 slotValid in reset", int'(slotValid), 0);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(slotValid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 after reset",
        int'({slotValid, busy, done}), 0);

    for (int m = 0; m < 16; m++)
      for (int c = 1; c <= 4; c++)
        runBlit(4'(m), c, 0);
    for (int m = 0; m < 16; m++)
      runBlit(4'(m), 3, 1);
    runBlit(4'hF, 9, 0);
    runBlit(4'h4, 9, 1);
    runBlit(4'h7, 7, 1);
    runBlit(4'hF, 2, 2);
    runBlit(4'h7, 2, 2);
    runBlit(4'h1, 3, 2);
    runBlit(4'h9, 3, 2);
    runBlit(4'hF, 0, 0);
    runBlit(4'h0, 5, 0);

    if (!summaryDone) begin
      summaryDone = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!summaryDone) begin
      summaryDone = 1;
      applied++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

endmodule